// File: doc/BRIEF.md
# Prescaled Reloading Event Counter

This block divides a stream of single-cycle tick enables by a programmable ratio and counts how many divided periods have elapsed. A down-counter steps toward zero on each tick. On the tick that finds it already at zero, it reloads from a prescale register, and an event counter advances by one on that same tick. A reload value of zero therefore keeps the down-counter parked at zero, and every tick then becomes an event.

Software reaches all three state registers through a single-cycle write port with a two-bit register select. The current down-count and the event count are visible as output buses. Two other blocks are expected to sit around this one: a bus decoder that drives the write port, and a tick generator that derives the enable from a faster clock, nominally at 20 MHz.

Top module: `prescaled_event_counter`

## Requirements
- R1: After a synchronous active-low reset, the prescale register, the down-count and the event count are all zero.
- R2: On a tick with a non-zero down-count, the down-count decreases by one and the event count is unchanged.
- R3: On a tick with a down-count of zero, the down-count takes the value of the prescale register.
- R4: The event count rises by one on exactly the ticks that find the down-count at zero. With prescale 5 and a starting down-count of 7, successive ticks give 6,5,4,3,2,1,0,5,4,3,2,1,0,5, and the event count steps on the 8th and 14th ticks.
- R5: With prescale 0, the down-count stays at zero once it gets there, and the event count rises on every tick.
- R6: A write to the prescale register (select 2'b00) leaves the current down-count unchanged. The new value first shows at the next reload.
- R7: With the tick low and no write, the down-count and the event count hold their values.
- R8: A write to the down-count (select 2'b01) or to the event count (select 2'b10) takes effect in full, even when a tick arrives in the same cycle.
- R9: The event count wraps from all-ones to zero and gives no other indication.
- R10: A write with select 2'b11 changes no register.
- R11: A reload in the same cycle as a prescale write uses the prescale value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_i | input | 1 | Single-cycle prescale tick enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 00 prescale, 01 down-count, 10 event count, 11 none |
| wr_data_i | input | DATA_W | Write data, low bits used |
| down_count_o | output | PRE_W | Current down-count |
| event_count_o | output | CNT_W | Current event count |

## Verification
The bench builds the block with its default widths, 32 bits for the prescaler, the event counter and the write data. Direct writes can place either counter at any value, so the all-ones wrap and reloads from large or zero prescale values are reached in a handful of ticks rather than after billions. A full 32-bit period is never run out. The cycles the bench checks most closely are the ones where a reload coincides with a write.

// File: rtl/pec_pkg.sv
// Package: shared encodings for the prescaled event counter.
// Assumes a two-bit write select supplied by an external bus decoder.
package pec_pkg;

    typedef enum logic [1:0] {
        SEL_PRESCALE = 2'b00,
        SEL_DOWN     = 2'b01,
        SEL_EVENT    = 2'b10,
        SEL_NONE     = 2'b11
    } wr_sel_e;

endpackage

// File: rtl/pec_prescale_reg.sv
// Module: holds the reload value for the down-counter.
// Assumes a load strobe that is already decoded; the value changes only on a load.
module pec_prescale_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic [W-1:0] value_o
);

    logic [W-1:0] value_q;

    // Keep the reload value; clear it on reset, replace it on a load.
    always_ff @(posedge clk) begin
        if (!rst_n)      value_q <= '0;
        else if (load_i) value_q <= load_val_i;
    end

    assign value_o = value_q;

endmodule

// File: rtl/pec_downcount.sv
// Module: down-counter that reloads on the tick after reaching zero.
// Assumes tick_i is a one-cycle enable. A load has priority over the tick.
// expire_o flags a tick that lands on a zero count, which is the reload event.
module pec_downcount #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic [W-1:0] reload_val_i,
    output logic [W-1:0] count_o,
    output logic         expire_o
);

    logic [W-1:0] count_q;
    logic         at_zero;

    assign at_zero  = (count_q == '0);
    assign expire_o = tick_i && at_zero;

    // Step the count: a load wins, otherwise a tick reloads at zero or decrements.
    always_ff @(posedge clk) begin
        if (!rst_n)        count_q <= '0;
        else if (load_i)   count_q <= load_val_i;
        else if (expire_o) count_q <= reload_val_i;
        else if (tick_i)   count_q <= count_q - 1'b1;
    end

    assign count_o = count_q;

endmodule

// File: rtl/pec_event_count.sv
// Module: wrapping event counter.
// Assumes inc_i is a one-cycle pulse. A load has priority over the increment.
// The count wraps silently at 2^W.
module pec_event_count #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic [W-1:0] count_o
);

    logic [W-1:0] count_q;

    // Count events: a load wins, otherwise add one on each pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)      count_q <= '0;
        else if (load_i) count_q <= load_val_i;
        else if (inc_i)  count_q <= count_q + 1'b1;
    end

    assign count_o = count_q;

endmodule

// File: rtl/prescaled_event_counter.sv
// Module: top level of the prescaled reloading event counter.
// Decodes the write port into per-register loads and wires the prescale
// register, the down-counter and the event counter together.
// Assumes PRE_W and CNT_W are no larger than DATA_W, and that tick_i is a
// one-cycle enable in the clk domain.
module prescaled_event_counter #(
    parameter int PRE_W  = 32,
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_sel_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [PRE_W-1:0]  down_count_o,
    output logic [CNT_W-1:0]  event_count_o
);
    import pec_pkg::*;

    localparam int NUM_TARGETS = 3;

    logic [NUM_TARGETS-1:0] load_vec;
    logic [PRE_W-1:0]       prescale_q;
    logic                   reload_evt;

    // Turn the write strobe and select into one load strobe per register.
    always_comb begin
        load_vec = '0;
        if (wr_en_i) begin
            for (int i = 0; i < NUM_TARGETS; i++) begin
                if (wr_sel_i == 2'(i)) load_vec[i] = 1'b1;
            end
        end
    end

    pec_prescale_reg #(.W(PRE_W)) u_prescale (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_vec[SEL_PRESCALE]),
        .load_val_i (wr_data_i[PRE_W-1:0]),
        .value_o    (prescale_q)
    );

    pec_downcount #(.W(PRE_W)) u_down (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_i),
        .load_i       (load_vec[SEL_DOWN]),
        .load_val_i   (wr_data_i[PRE_W-1:0]),
        .reload_val_i (prescale_q),
        .count_o      (down_count_o),
        .expire_o     (reload_evt)
    );

    pec_event_count #(.W(CNT_W)) u_event (
        .clk        (clk),
        .rst_n      (rst_n),
        .inc_i      (reload_evt),
        .load_i     (load_vec[SEL_EVENT]),
        .load_val_i (wr_data_i[CNT_W-1:0]),
        .count_o    (event_count_o)
    );

endmodule

// File: rtl/pec_checker.sv
// Module: assertion checker for the prescaled event counter, bound to the top.
module pec_checker #(
    parameter int PRE_W  = 32,
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_i,
    input logic              wr_en_i,
    input logic [1:0]        wr_sel_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic [PRE_W-1:0]  down_count_o,
    input logic [CNT_W-1:0]  event_count_o,
    input logic [PRE_W-1:0]  prescale_q
);

    logic wr_down, wr_evt;
    assign wr_down = wr_en_i && (wr_sel_i == 2'b01);
    assign wr_evt  = wr_en_i && (wr_sel_i == 2'b10);

    a_r2_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && down_count_o != '0 && !wr_down)
        |=> down_count_o == $past(down_count_o) - 1'b1);

    a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && down_count_o == '0 && !wr_down)
        |=> down_count_o == $past(prescale_q));

    a_r4_event_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && down_count_o == '0 && !wr_evt)
        |=> event_count_o == $past(event_count_o) + 1'b1);

    a_r7_hold_event: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !wr_evt) |=> $stable(event_count_o));

    a_r7_hold_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !wr_down) |=> $stable(down_count_o));

    a_r8_down_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_down |=> down_count_o == $past(wr_data_i[PRE_W-1:0]));

    a_r8_event_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_evt |=> event_count_o == $past(wr_data_i[CNT_W-1:0]));

endmodule

bind prescaled_event_counter pec_checker #(
    .PRE_W(PRE_W), .CNT_W(CNT_W), .DATA_W(DATA_W)
) u_pec_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_i        (tick_i),
    .wr_en_i       (wr_en_i),
    .wr_sel_i      (wr_sel_i),
    .wr_data_i     (wr_data_i),
    .down_count_o  (down_count_o),
    .event_count_o (event_count_o),
    .prescale_q    (prescale_q)
);

// File: tb/test_prescaled_event_counter.sv
module test_prescaled_event_counter;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_sel = 2'b00;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] down_count;
    logic [W-1:0] event_count;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    prescaled_event_counter #(.PRE_W(W), .CNT_W(W), .DATA_W(W)) i_prescaled_event_counter (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_i        (tick),
        .wr_en_i       (wr_en),
        .wr_sel_i      (wr_sel),
        .wr_data_i     (wr_data),
        .down_count_o  (down_count),
        .event_count_o (event_count)
    );

    // One clock: drive the inputs, pass the edge, sample 1 ns after it.
    task automatic cyc(input logic t, input logic we, input logic [1:0] sel, input logic [W-1:0] d);
        tick = t; wr_en = we; wr_sel = sel; wr_data = d;
        @(posedge clk); #1;
        tick = 1'b0; wr_en = 1'b0;
    endtask

    task automatic chk(input string req, input logic [W-1:0] dn_exp, input logic [W-1:0] ev_exp);
        checks++;
        if (down_count !== dn_exp || event_count !== ev_exp) begin
            errors++;
            $display("FAIL %s: down=%0d event=%0d expected down=%0d event=%0d",
                     req, down_count, event_count, dn_exp, ev_exp);
        end
    endtask

    task automatic setup(input logic [W-1:0] pre, input logic [W-1:0] dn, input logic [W-1:0] ev);
        cyc(1'b0, 1'b1, 2'b00, pre);
        cyc(1'b0, 1'b1, 2'b01, dn);
        cyc(1'b0, 1'b1, 2'b10, ev);
    endtask

    task automatic t_reset();
        chk("R1", 0, 0);
        cyc(1'b1, 1'b0, 2'b00, 0);   // tick at zero reloads the zero prescale
        chk("R1", 0, 1);
    endtask

    task automatic t_sequence();
        int exp_dn [14] = '{6,5,4,3,2,1,0,5,4,3,2,1,0,5};
        int exp_ev;
        setup(5, 7, 0);
        chk("R2", 7, 0);
        exp_ev = 0;
        for (int i = 0; i < 14; i++) begin
            if (i == 7 || i == 13) exp_ev++;
            cyc(1'b1, 1'b0, 2'b00, 0);
            chk((i == 7 || i == 13) ? "R4" : (i < 7 ? "R2" : "R3"), exp_dn[i], exp_ev);
        end
    endtask

    task automatic t_zero_prescale();
        setup(0, 2, 10);
        cyc(1'b1, 1'b0, 2'b00, 0); chk("R5", 1, 10);
        cyc(1'b1, 1'b0, 2'b00, 0); chk("R5", 0, 10);
        cyc(1'b1, 1'b0, 2'b00, 0); chk("R5", 0, 11);
        cyc(1'b1, 1'b0, 2'b00, 0); chk("R5", 0, 12);
        cyc(1'b1, 1'b0, 2'b00, 0); chk("R5", 0, 13);
    endtask

    task automatic t_prescale_write();
        setup(2, 1, 0);
        cyc(1'b0, 1'b1, 2'b00, 9); chk("R6", 1, 0);
        cyc(1'b1, 1'b0, 2'b00, 0); chk("R6", 0, 0);
        cyc(1'b1, 1'b0, 2'b00, 0); chk("R6", 9, 1);
    endtask

    task automatic t_idle();
        setup(3, 4, 6);
        for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0, 2'b00, 0);
        chk("R7", 4, 6);
    endtask

    task automatic t_priority();
        setup(3, 0, 20);
        cyc(1'b1, 1'b1, 2'b01, 100); chk("R8", 100, 21);
        cyc(1'b1, 1'b1, 2'b10, 50);  chk("R8", 99, 50);
        cyc(1'b0, 1'b1, 2'b01, 0);   chk("R8", 0, 50);
        cyc(1'b1, 1'b1, 2'b10, 7);   chk("R8", 3, 7);
    endtask

    task automatic t_wrap();
        setup(4, 0, 32'hFFFF_FFFF);
        cyc(1'b1, 1'b0, 2'b00, 0); chk("R9", 4, 0);
    endtask

    task automatic t_ignored_sel();
        setup(6, 5, 8);
        cyc(1'b0, 1'b1, 2'b11, 32'h1234_5678); chk("R10", 5, 8);
        setup(6, 0, 8);   // reload reveals the prescale is still 6
        cyc(1'b1, 1'b1, 2'b11, 32'h1234_5678); chk("R10", 6, 9);
    endtask

    task automatic t_reload_collision();
        setup(4, 0, 0);
        cyc(1'b1, 1'b1, 2'b00, 7); chk("R11", 4, 1);
        cyc(1'b0, 1'b1, 2'b01, 0);
        cyc(1'b1, 1'b0, 2'b00, 0); chk("R11", 7, 2);
    endtask

    initial begin : watchdog
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_sequence();
        t_zero_prescale();
        t_prescale_write();
        t_idle();
        t_priority();
        t_wrap();
        t_ignored_sel();
        t_reload_collision();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule